// File: doc/BRIEF.md
# Flash Erase Sequencer with Write Inhibit

This block is the erase engine of a parallel NOR flash device. A command decoder ahead of it presents an erase kind and a target address. The block accepts the command only on a qualified write strobe: chip enable and write enable both low, output enable high, and no low-supply indication. That low phase must last a minimum number of clock cycles. The command is committed in the cycle the strobe is released, and shorter strobes count as noise.

Once a command is committed, the block finds the byte range it covers. The range is one sector, one block of sixteen sectors, or the whole array. The block then walks that range one byte per clock, in ascending order, writing FFh into its on-chip byte array. Nothing needs to be programmed first. While the walk runs, a busy flag is high and every further command is dropped. When the walk ends, the block goes back to standby.

A combinational read port lets the surrounding logic observe the array at any time. The control pins are plain levels, and there is no handshake at the edge of the block.

Top module: `flash_erase_seq`

## Requirements
- R1: Kind code 01 erases one sector of 2^SECTOR_W bytes. The sector is selected by address bits [ADDR_W-1:SECTOR_W]. Every byte in that sector becomes FFh, and all other bytes keep their value.
- R2: Kind code 10 erases one block of sixteen adjacent sectors. The block is selected by address bits [ADDR_W-1:SECTOR_W+4]. Every byte in that block becomes FFh, and all other bytes keep their value.
- R3: Kind code 11 erases every byte of the array to FFh, whatever the address.
- R4: The erase walk writes one byte per cycle in ascending address order. The busy output rises in the cycle after the commit and stays high for exactly as many cycles as the range has bytes. The block then returns to standby with busy low.
- R5: A write is accepted only if we_n and ce_n are both low, with oe_n high and supply_low low, for at least MIN_PULSE consecutive cycles. It commits in the first cycle in which we_n or ce_n is high again, provided oe_n is high and supply_low is low in that cycle. Kind and address are taken from the last cycle of the low phase.
- R6: A qualified low phase shorter than MIN_PULSE cycles starts nothing, and the array is left unchanged.
- R7: While oe_n is low, no write is accepted.
- R8: While supply_low is high, no write is accepted.
- R9: While ce_n is high, we_n pulses start nothing.
- R10: While busy is high, any new command is ignored, and the running walk keeps its range and its length.
- R11: Kind code 00 is a no-operation: busy stays low and the array is left unchanged.
- R12: After reset, busy is low and each byte at address a holds (a*37+11) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; when low, writes are inhibited |
| we_n | input | 1 | Write strobe, active low |
| supply_low | input | 1 | Digital low-supply indication; when high, writes are inhibited |
| cmd_kind | input | 2 | Pre-decoded erase kind: 00 none, 01 sector, 10 block, 11 chip |
| cmd_addr | input | ADDR_W | Target address for the erase |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Byte stored at rd_addr (combinational) |
| busy | output | 1 | High while an erase walk is running |

## Verification
On every cycle the assertions check three things:
- no walk can start while the output enable or the supply indication inhibits, or while the chip is deselected;
- every start was preceded by a low strobe;
- the walk steps one address per cycle, keeps its end address fixed while busy, and drops busy only after writing that end address.

Some behaviour is visible only through the bench's scenarios:
- which bytes end up at FFh and which keep their reset value;
- the exact busy length for each erase kind;
- the threshold between short and long pulses;
- the no-op kind;
- dropping a command issued during a walk.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    ERS_NONE   = 2'b00,
    ERS_SECTOR = 2'b01,
    ERS_BLOCK  = 2'b10,
    ERS_CHIP   = 2'b11
  } ers_kind_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Content loaded into the array by reset.
  function automatic logic [7:0] seed_byte(input int a);
    int v;
    v = (a * 37 + 11) % 256;
    return v[7:0];
  endfunction

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              supply_low,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              commit,
  output ers_kind_e         commit_kind,
  output logic [ADDR_W-1:0] commit_addr
);

  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_PULSE);

  logic             strobe_low;
  logic             write_ok;
  logic [CNT_W-1:0] run_cnt;
  ers_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;

  assign strobe_low = !we_n && !ce_n;
  assign write_ok   = oe_n && !supply_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      kind_q  <= ERS_NONE;
      addr_q  <= '0;
    end else if (strobe_low && write_ok) begin
      if (run_cnt != CNT_SAT) begin
        run_cnt <= run_cnt + 1'b1;
      end
      kind_q <= ers_kind_e'(cmd_kind);
      addr_q <= cmd_addr;
    end else begin
      run_cnt <= '0;
    end
  end

  assign commit      = !strobe_low && write_ok && (run_cnt == CNT_SAT);
  assign commit_kind = kind_q;
  assign commit_addr = addr_q;

endmodule

// File: rtl/erase_range.sv
module erase_range
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SECTOR_W   = 5,
  parameter int BLK_SECT_W = 4
) (
  input  ers_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  output logic              valid,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);

  localparam int BLK_SHIFT = SECTOR_W + BLK_SECT_W;
  localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SEC_MASK = ALL_ONES << SECTOR_W;
  localparam logic [ADDR_W-1:0] BLK_MASK =
    (BLK_SHIFT >= ADDR_W) ? '0 : (ALL_ONES << BLK_SHIFT);

  always_comb begin
    valid = 1'b1;
    lo    = '0;
    hi    = '0;
    unique case (kind)
      ERS_SECTOR: begin
        lo = addr & SEC_MASK;
        hi = addr | ~SEC_MASK;
      end
      ERS_BLOCK: begin
        lo = addr & BLK_MASK;
        hi = addr | ~BLK_MASK;
      end
      ERS_CHIP: begin
        lo = '0;
        hi = ALL_ONES;
      end
      default: begin
        valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/erase_walker.sv
module erase_walker #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] range_lo,
  input  logic [ADDR_W-1:0] range_hi,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] end_addr
);

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      end_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cur_q  <= range_lo;
        end_q  <= range_hi;
      end
    end else if (cur_q == end_q) begin
      busy_q <= 1'b0;
    end else begin
      cur_q <= cur_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign wr_en    = busy_q;
  assign wr_addr  = cur_q;
  assign end_addr = end_q;

endmodule

// File: rtl/erase_array.sv
module erase_array
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= seed_byte(i);
      end
    end else if (wr_en) begin
      mem[wr_addr] <= ERASED_BYTE;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SECTOR_W   = 5,
  parameter int BLK_SECT_W = 4,
  parameter int MIN_PULSE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              supply_low,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  logic              commit;
  ers_kind_e         commit_kind;
  logic [ADDR_W-1:0] commit_addr;
  logic              rng_valid;
  logic [ADDR_W-1:0] rng_lo;
  logic [ADDR_W-1:0] rng_hi;
  logic              start;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] end_addr;

  strobe_filter #(
    .ADDR_W   (ADDR_W),
    .MIN_PULSE(MIN_PULSE)
  ) filt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .supply_low (supply_low),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .commit     (commit),
    .commit_kind(commit_kind),
    .commit_addr(commit_addr)
  );

  erase_range #(
    .ADDR_W    (ADDR_W),
    .SECTOR_W  (SECTOR_W),
    .BLK_SECT_W(BLK_SECT_W)
  ) rng_i (
    .kind (commit_kind),
    .addr (commit_addr),
    .valid(rng_valid),
    .lo   (rng_lo),
    .hi   (rng_hi)
  );

  assign start = commit && rng_valid;

  erase_walker #(
    .ADDR_W(ADDR_W)
  ) walk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .range_lo(rng_lo),
    .range_hi(rng_hi),
    .busy    (busy),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .end_addr(end_addr)
  );

  erase_array #(
    .ADDR_W(ADDR_W)
  ) mem_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              supply_low,
  input logic              busy,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] end_addr
);

  AST_SUPPLY_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && supply_low) |=> !busy); // R8

  AST_OE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !oe_n) |=> !busy); // R7

  AST_CE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(ce_n)) |=> !busy); // R9

  AST_START_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!we_n && !ce_n, 2)); // R5

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1))); // R4

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (end_addr == $past(end_addr))); // R10

  AST_END_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(wr_addr) == $past(end_addr))); // R4

endmodule

bind flash_erase_seq flash_erase_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .supply_low(supply_low),
  .busy      (busy),
  .wr_addr   (wr_addr),
  .end_addr  (end_addr)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int SECTOR_W   = 5;
  localparam int MIN_PULSE  = 3;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int SEC_BYTES  = 1 << SECTOR_W;
  localparam int BLK_BYTES  = SEC_BYTES * 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n, oe_n, we_n, supply_low;
  logic [1:0]        cmd_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              busy;

  int checks = 0;
  int errors = 0;
  int total_busy = 0;

  flash_erase_seq #(
    .ADDR_W    (ADDR_W),
    .SECTOR_W  (SECTOR_W),
    .BLK_SECT_W(4),
    .MIN_PULSE (MIN_PULSE)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .supply_low(supply_low),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (busy === 1'b1) total_busy++;
  end

  function automatic logic [7:0] pat(input int a);
    int v;
    v = (a * 37 + 11) % 256;
    return v[7:0];
  endfunction

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_array(input string req, input bit erased, input int lo, input int hi);
    int bad = 0;
    int bad_addr = 0;
    logic [7:0] bad_act = '0;
    logic [7:0] bad_exp = '0;
    logic [7:0] exp;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ADDR_W'(a);
      #1;
      exp = (erased && a >= lo && a <= hi) ? 8'hFF : pat(a);
      if (rd_data !== exp) begin
        if (bad == 0) begin
          bad_addr = a;
          bad_act  = rd_data;
          bad_exp  = exp;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d bytes wrong, first at %0d actual %02h expected %02h",
               req, bad, bad_addr, bad_act, bad_exp);
    end
  endtask

  task automatic idle_pins();
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; supply_low = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_pins();
    cmd_kind = 2'b00; cmd_addr = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Hold the strobe low for len rising edges, then release it.
  task automatic issue(input logic [1:0] kind, input int addr, input int len,
                       input logic oe_v, input logic sup_v, input logic ce_v);
    we_n = 1'b0; ce_n = ce_v; oe_n = oe_v; supply_low = sup_v;
    cmd_kind = kind; cmd_addr = ADDR_W'(addr);
    repeat (len) @(negedge clk);
    idle_pins();
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy === 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_case(input string req, input logic [1:0] kind, input int addr,
                          input int len, input logic oe_v, input logic sup_v,
                          input logic ce_v, input bit exp_start, input int lo,
                          input int hi);
    int snap;
    do_reset();
    snap = total_busy;
    issue(kind, addr, len, oe_v, sup_v, ce_v);
    @(negedge clk);
    check_int({req, " busy one cycle after release (R4)"}, int'(busy), int'(exp_start));
    settle();
    check_int({req, " busy length (R4)"}, total_busy - snap, exp_start ? (hi - lo + 1) : 0);
    check_array({req, " array contents"}, exp_start, lo, hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0;
    idle_pins();
    cmd_kind = 2'b00; cmd_addr = '0; rd_addr = '0;

    // R12: reset state
    do_reset();
    check_int("R12 busy after reset", int'(busy), 0);
    check_array("R12 reset pattern", 1'b0, 0, 0);

    // R1: sector erase at several sectors
    run_case("R1 sector 0",  2'b01, 5,                    4, 1'b1, 1'b0, 1'b0, 1'b1, 0,               SEC_BYTES - 1);
    run_case("R1 sector 17", 2'b01, 17 * SEC_BYTES + 9,   4, 1'b1, 1'b0, 1'b0, 1'b1, 17 * SEC_BYTES,  18 * SEC_BYTES - 1);
    run_case("R1 sector 31", 2'b01, 31 * SEC_BYTES + 31,  3, 1'b1, 1'b0, 1'b0, 1'b1, 31 * SEC_BYTES,  DEPTH - 1);

    // R2: block erase
    run_case("R2 block 0", 2'b10, 3,               4, 1'b1, 1'b0, 1'b0, 1'b1, 0,         BLK_BYTES - 1);
    run_case("R2 block 1", 2'b10, BLK_BYTES + 200, 4, 1'b1, 1'b0, 1'b0, 1'b1, BLK_BYTES, DEPTH - 1);

    // R3: chip erase
    run_case("R3 chip", 2'b11, 700, 5, 1'b1, 1'b0, 1'b0, 1'b1, 0, DEPTH - 1);

    // R5 / R6: pulse-width sweep around MIN_PULSE
    for (int len = 1; len <= MIN_PULSE + 2; len++) begin
      if (len >= MIN_PULSE)
        run_case("R5 long pulse", 2'b01, 3 * SEC_BYTES + 1, len, 1'b1, 1'b0, 1'b0, 1'b1,
                 3 * SEC_BYTES, 4 * SEC_BYTES - 1);
      else
        run_case("R6 short pulse", 2'b01, 3 * SEC_BYTES + 1, len, 1'b1, 1'b0, 1'b0, 1'b0,
                 3 * SEC_BYTES, 4 * SEC_BYTES - 1);
    end

    // R7, R8, R9: inhibit conditions
    run_case("R7 oe_n low",       2'b11, 0, 5, 1'b0, 1'b0, 1'b0, 1'b0, 0, DEPTH - 1);
    run_case("R8 supply_low high", 2'b11, 0, 5, 1'b1, 1'b1, 1'b0, 1'b0, 0, DEPTH - 1);
    run_case("R9 ce_n high",      2'b11, 0, 5, 1'b1, 1'b0, 1'b1, 1'b0, 0, DEPTH - 1);

    // R11: kind 00
    run_case("R11 no-op kind", 2'b00, 64, 5, 1'b1, 1'b0, 1'b0, 1'b0, 0, DEPTH - 1);

    // R10: commands during a running sector walk are dropped
    do_reset();
    snap = total_busy;
    issue(2'b01, 5, MIN_PULSE, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_int("R10 first walk started", int'(busy), 1);
    issue(2'b10, BLK_BYTES + 40, MIN_PULSE, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    issue(2'b11, 0, MIN_PULSE, 1'b1, 1'b0, 1'b0);
    settle();
    check_int("R10 walk length unchanged", total_busy - snap, SEC_BYTES);
    check_array("R10 only first sector erased", 1'b1, 0, SEC_BYTES - 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule